// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is a transmit-only bus master for a two-wire open-drain serial bus. Software first checks the bus-busy flag and then pulses a start command. The engine pulls SDA low while SCL stays high and then parks with SCL low. Each byte written to the data register waits in a holding register until the engine is parked. It then moves into a shift register and goes out as a frame of 1 to 8 bits. The frame is followed by one acknowledge clock, during which SDA is released and the receiver's answer is sampled. The first frame after a start is by convention the 7-bit target address with a direction bit in the lowest position, where 0 means master-to-target. The engine sends it like any other byte.

A transmit-empty flag shows when the holding register can take the next byte. An interrupt flag marks the end of the start condition and the end of every acknowledge clock, and it can be masked onto an interrupt line. A stop request that arrives while the bus is owned is held until the engine is parked with no byte waiting. The engine then drives the stop condition and frees the bus. SCL timing comes from two phase lengths counted in system clocks, so one instance can serve several bus speeds.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset, scl_o and sda_o are 1 (released), and bus_busy, tx_empty, irq_flag and nack are 0.
- R2: If go_start is sampled while the bus is idle, then from the next cycle sda_o is 0, scl_o stays 1 and bus_busy is 1. After hi_cyc clocks, scl_o falls, and on that same edge tx_empty and irq_flag are set.
- R3: A go_start pulse sampled while bus_busy is 1 has no effect on SCL, SDA or the flags.
- R4: A write (wr_en) stores wr_data and clears tx_empty on the next edge. When the parked engine moves a waiting byte into its shift register, tx_empty is set again. A write on that same edge wins, and the new byte waits.
- R5: frame_bits gives the number of data bits per frame, 1 to 7, and the value 0 means 8.
- R6: With lsb_first=0 the frame sends byte bits 7, 6, … downward (the top n bits). With lsb_first=1 it sends bits 0, 1, … upward (the low n bits). Mode and length are taken when the byte is loaded.
- R7: During a transfer, every SCL low phase lasts lo_cyc clocks and every SCL high phase lasts hi_cyc clocks. A value of 0 counts as 1.
- R8: SDA changes only while SCL is low, except at the start (SDA falls) and the stop (SDA rises).
- R9: After the last data bit, SDA is released for one extra SCL pulse. sda_in is sampled on the last clock of that high phase and stored in nack (1 = not acknowledged). irq_flag is set on the edge where SCL then falls.
- R10: An irq_clr pulse clears irq_flag unless a setting event falls on the same edge, in which case the set wins. irq equals irq_flag AND irq_en.
- R11: A stop_req pulse sampled while bus_busy is 1 is held until the engine is parked with no byte waiting, so a waiting byte is sent first. The stop then runs as follows: SDA low with SCL low for lo_cyc clocks, then SCL high for hi_cyc clocks, then SDA rises, then hi_cyc idle clocks, after which bus_busy clears. A stop_req sampled while bus_busy is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Byte to transmit |
| go_start | input | 1 | Start command pulse |
| stop_req | input | 1 | Stop request pulse |
| irq_clr | input | 1 | Clear pulse for irq_flag |
| irq_en | input | 1 | Interrupt mask |
| frame_bits | input | 3 | Data bits per frame (0 = 8) |
| lsb_first | input | 1 | Bit order select |
| lo_cyc | input | CW | SCL low phase length in clocks |
| hi_cyc | input | CW | SCL high phase length in clocks |
| sda_in | input | 1 | Sensed SDA line level |
| scl_o | output | 1 | SCL drive (0 = pull low, 1 = release) |
| sda_o | output | 1 | SDA drive (0 = pull low, 1 = release) |
| bus_busy | output | 1 | Bus owned by this master |
| tx_empty | output | 1 | Holding register can take a byte |
| irq_flag | output | 1 | Event flag |
| irq | output | 1 | Masked interrupt request |
| nack | output | 1 | Last acknowledge was high |

## Verification
The hardest situations to reach from the ports are the edge collisions around the parked state. One is a write landing on the same edge where the engine takes the waiting byte into the shift register. Another is a stop request arriving together with a byte, where the byte must go out first. The stimulus gets there by writing a second byte while the first one is still shifting, so it waits in the holding register. It also issues a byte and a stop request in the same cycle. A stop pulse given while the bus is idle, followed later by a real start, shows that the idle pulse was not latched.

// File: rtl/i2c_tx_master.sv
module i2c_tx_master #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          go_start,
  input  logic          stop_req,
  input  logic          irq_clr,
  input  logic          irq_en,
  input  logic [2:0]    frame_bits,
  input  logic          lsb_first,
  input  logic [CW-1:0] lo_cyc,
  input  logic [CW-1:0] hi_cyc,
  input  logic          sda_in,
  output logic          scl_o,
  output logic          sda_o,
  output logic          bus_busy,
  output logic          tx_empty,
  output logic          irq_flag,
  output logic          irq,
  output logic          nack
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_WAIT, S_BLO, S_BHI, S_ALO, S_AHI, S_SLO, S_SHI, S_SEND
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [7:0]    dreg, sreg;
  logic [3:0]    left;
  logic          lsb_r, full, stop_pend, scl_r, sda_r;

  wire [CW-1:0] lo_len = (lo_cyc == '0) ? CW'(1) : lo_cyc;
  wire [CW-1:0] hi_len = (hi_cyc == '0) ? CW'(1) : hi_cyc;
  wire          last   = (cnt == '0);
  wire          take   = (st == S_WAIT) && full;
  wire          begin_start = (st == S_IDLE) && go_start && !bus_busy;
  wire          start_done  = (st == S_START) && last;
  wire          ack_done    = (st == S_AHI) && last;
  wire          stop_done   = (st == S_SEND) && last;
  wire [3:0]    nbits  = (frame_bits == 3'd0) ? 4'd8 : {1'b0, frame_bits};
  wire          first_bit = lsb_first ? dreg[0] : dreg[7];
  wire          next_bit  = lsb_r ? sreg[1] : sreg[6];
  wire [7:0]    sreg_nx   = lsb_r ? {1'b0, sreg[7:1]} : {sreg[6:0], 1'b0};

  assign scl_o = scl_r;
  assign sda_o = sda_r;
  assign irq   = irq_flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      sreg  <= '0;
      left  <= '0;
      lsb_r <= 1'b0;
      scl_r <= 1'b1;
      sda_r <= 1'b1;
    end else begin
      if (!last) cnt <= cnt - CW'(1);
      case (st)
        S_IDLE:
          if (begin_start) begin
            st    <= S_START;
            sda_r <= 1'b0;
            cnt   <= hi_len - CW'(1);
          end
        S_START:
          if (last) begin
            st    <= S_WAIT;
            scl_r <= 1'b0;
          end
        S_WAIT:
          if (full) begin
            sreg  <= dreg;
            lsb_r <= lsb_first;
            left  <= nbits;
            sda_r <= first_bit;
            st    <= S_BLO;
            cnt   <= lo_len - CW'(1);
          end else if (stop_pend) begin
            sda_r <= 1'b0;
            st    <= S_SLO;
            cnt   <= lo_len - CW'(1);
          end
        S_BLO:
          if (last) begin
            scl_r <= 1'b1;
            st    <= S_BHI;
            cnt   <= hi_len - CW'(1);
          end
        S_BHI:
          if (last) begin
            scl_r <= 1'b0;
            cnt   <= lo_len - CW'(1);
            if (left > 4'd1) begin
              sreg  <= sreg_nx;
              sda_r <= next_bit;
              left  <= left - 4'd1;
              st    <= S_BLO;
            end else begin
              sda_r <= 1'b1;
              st    <= S_ALO;
            end
          end
        S_ALO:
          if (last) begin
            scl_r <= 1'b1;
            st    <= S_AHI;
            cnt   <= hi_len - CW'(1);
          end
        S_AHI:
          if (last) begin
            scl_r <= 1'b0;
            st    <= S_WAIT;
          end
        S_SLO:
          if (last) begin
            scl_r <= 1'b1;
            st    <= S_SHI;
            cnt   <= hi_len - CW'(1);
          end
        S_SHI:
          if (last) begin
            sda_r <= 1'b1;
            st    <= S_SEND;
            cnt   <= hi_len - CW'(1);
          end
        S_SEND:
          if (last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_busy  <= 1'b0;
      full      <= 1'b0;
      dreg      <= '0;
      tx_empty  <= 1'b0;
      irq_flag  <= 1'b0;
      nack      <= 1'b0;
      stop_pend <= 1'b0;
    end else begin
      if (begin_start)    bus_busy <= 1'b1;
      else if (stop_done) bus_busy <= 1'b0;

      full <= (full && !take) || wr_en;
      if (wr_en) dreg <= wr_data;

      if (wr_en)                    tx_empty <= 1'b0;
      else if (take || start_done)  tx_empty <= 1'b1;

      if (start_done || ack_done) irq_flag <= 1'b1;
      else if (irq_clr)           irq_flag <= 1'b0;

      if (ack_done) nack <= sda_in;

      if (stop_done)                  stop_pend <= 1'b0;
      else if (stop_req && bus_busy)  stop_pend <= 1'b1;
    end
  end

  AST_SDA_STILL_WHILE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && st != S_START && st != S_SEND) |-> sda_o == $past(sda_o)); // R8

  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && st != S_START) |=> st != S_START); // R3

  AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tx_empty); // R4

  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !start_done && !ack_done) |=> !irq_flag); // R10

  AST_NACK_ONLY_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_AHI) |=> $stable(nack)); // R9

  AST_BUS_FREED_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> (st == S_IDLE && scl_o && sda_o)); // R11

endmodule

// File: tb/i2c_tx_master_tb.sv
`timescale 1ns/1ps
module i2c_tx_master_tb;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, go_start = 0, stop_req = 0, irq_clr = 0, irq_en = 0, lsb_first = 0;
  logic [7:0] wr_data = '0;
  logic [2:0] frame_bits = '0;
  logic [CW-1:0] lo_cyc = 8'd3, hi_cyc = 8'd2;
  logic slave_low = 1'b0;
  logic sda_in;
  logic scl_o, sda_o, bus_busy, tx_empty, irq_flag, irq, nack;

  always #2 clk = ~clk;

  assign sda_in = sda_o & ~slave_low;

  i2c_tx_master #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .go_start(go_start),
    .stop_req(stop_req), .irq_clr(irq_clr), .irq_en(irq_en), .frame_bits(frame_bits),
    .lsb_first(lsb_first), .lo_cyc(lo_cyc), .hi_cyc(hi_cyc), .sda_in(sda_in),
    .scl_o(scl_o), .sda_o(sda_o), .bus_busy(bus_busy), .tx_empty(tx_empty),
    .irq_flag(irq_flag), .irq(irq), .nack(nack)
  );

  int checks = 0, failures = 0;
  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: a queue of per-cycle line values with event codes
  int q[$];
  bit m_scl = 1, m_sda = 1, m_busy = 0, m_empty = 0, m_irq = 0, m_nack = 0, m_full = 0, m_sp = 0;
  logic [7:0] m_data = '0;
  bit busy0, full0, sp0;
  logic [7:0] d0;
  int lo, hi, nb, it, act;

  task automatic push(int n, int c, int d, int a);
    repeat (n) q.push_back(a * 4 + c * 2 + d);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_scl = 1; m_sda = 1; m_busy = 0; m_empty = 0; m_irq = 0; m_nack = 0;
      m_full = 0; m_sp = 0; m_data = '0;
    end else begin
      busy0 = m_busy; full0 = m_full; sp0 = m_sp; d0 = m_data;
      lo = (lo_cyc == 0) ? 1 : int'(lo_cyc);
      hi = (hi_cyc == 0) ? 1 : int'(hi_cyc);
      act = 0;
      if (q.size() == 0) begin
        if (!busy0) begin
          if (go_start) begin
            m_busy = 1;
            push(hi, 1, 0, 0);
            push(1, 0, 0, 1);
          end
        end else if (full0) begin
          nb = (frame_bits == 0) ? 8 : int'(frame_bits);
          for (int i = 0; i < nb; i++) begin
            push(lo, 0, lsb_first ? d0[i] : d0[7-i], 0);
            push(hi, 1, lsb_first ? d0[i] : d0[7-i], 0);
          end
          push(lo, 0, 1, 0);
          push(hi, 1, 1, 0);
          push(1, 0, 1, 2);
          m_full = 0; m_empty = 1;
        end else if (sp0) begin
          push(lo, 0, 0, 0);
          push(hi, 1, 0, 0);
          push(hi, 1, 1, 0);
          push(1, 1, 1, 3);
        end
      end
      if (q.size() != 0) begin
        it = q.pop_front();
        m_scl = it[1]; m_sda = it[0]; act = it >> 2;
      end
      if (act == 1) m_empty = 1;
      if (act == 2) m_nack = sda_in;
      if (act == 3) m_busy = 0;
      if (act == 1 || act == 2) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      if (act == 3) m_sp = 0;
      else if (stop_req && busy0) m_sp = 1;
      if (wr_en) begin m_full = 1; m_empty = 0; m_data = wr_data; end
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) if (rst_n && cmp_on) begin
    chk(scl_o === m_scl,        "R7 scl timing",  scl_o, m_scl);
    chk(sda_o === m_sda,        "R6 R8 sda",      sda_o, m_sda);
    chk(bus_busy === m_busy,    "R2 bus_busy",    bus_busy, m_busy);
    chk(tx_empty === m_empty,   "R4 tx_empty",    tx_empty, m_empty);
    chk(irq_flag === m_irq,     "R10 irq_flag",   irq_flag, m_irq);
    chk(irq === (m_irq & irq_en), "R10 irq",      irq, m_irq & irq_en);
    chk(nack === m_nack,        "R9 nack",        nack, m_nack);
  end

  // line monitor: bits seen at SCL rise, start and stop conditions
  bit cap[$];
  bit p_scl = 1, p_sda = 1;
  int starts = 0, stops = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!p_scl && scl_o) cap.push_back(sda_o);
      if (p_scl && scl_o && p_sda && !sda_o) starts++;
      if (p_scl && scl_o && !p_sda && sda_o) stops++;
    end
    p_scl = scl_o; p_sda = sda_o;
  end

  task automatic wait_irq(string tag);
    for (int i = 0; i < 2000 && !irq_flag; i++) @(negedge clk);
    chk(irq_flag === 1'b1, tag, irq_flag, 1);
  endtask

  task automatic wait_free(string tag);
    for (int i = 0; i < 2000 && bus_busy; i++) @(negedge clk);
    chk(bus_busy === 1'b0, tag, bus_busy, 0);
  endtask

  function automatic bit exp_bit(logic [7:0] d, bit lsb, int i);
    return lsb ? d[i] : d[7-i];
  endfunction

  task automatic send(logic [7:0] d, logic [2:0] fb, bit lsb, bit ack, string tag);
    int n;
    n = (fb == 0) ? 8 : int'(fb);
    @(negedge clk);
    frame_bits = fb; lsb_first = lsb; slave_low = ack;
    irq_clr = 1; wr_en = 1; wr_data = d;
    cap.delete();
    @(negedge clk);
    irq_clr = 0; wr_en = 0;
    chk(tx_empty === 1'b0, {tag, " R4 empty cleared by write"}, tx_empty, 0);
    wait_irq({tag, " R9 irq after ack"});
    chk(cap.size() == n + 1, {tag, " R5 clock count"}, cap.size(), n + 1);
    for (int i = 0; i < n && i < cap.size(); i++)
      chk(cap[i] == exp_bit(d, lsb, i), {tag, " R6 bit value"}, cap[i], exp_bit(d, lsb, i));
    if (cap.size() > n) chk(cap[n] == 1'b1, {tag, " R9 sda released at ack"}, cap[n], 1);
    chk(nack === !ack, {tag, " R9 nack status"}, nack, !ack);
    slave_low = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1; cmp_on = 1;
    @(negedge clk);
    chk(scl_o === 1 && sda_o === 1, "R1 lines released", {scl_o, sda_o}, 3);
    chk(bus_busy === 0, "R1 busy", bus_busy, 0);
    chk(tx_empty === 0, "R1 empty", tx_empty, 0);
    chk(irq_flag === 0 && nack === 0, "R1 irq and nack", {irq_flag, nack}, 0);

    irq_en = 1;
    @(negedge clk) go_start = 1;
    @(negedge clk) go_start = 0;
    chk(bus_busy === 1 && sda_o === 0 && scl_o === 1, "R2 start condition",
        {bus_busy, sda_o, scl_o}, 5);
    wait_irq("R2 irq after start");
    chk(tx_empty === 1 && scl_o === 0, "R2 empty and scl low", {tx_empty, scl_o}, 2);
    chk(starts == 1, "R2 one start seen", starts, 1);
    chk(irq === 1, "R10 irq output", irq, 1);

    @(negedge clk) go_start = 1;
    @(negedge clk) go_start = 0;
    repeat (10) @(negedge clk);
    chk(starts == 1 && scl_o === 0 && sda_o === 0, "R3 start ignored while busy",
        starts, 1);

    @(negedge clk) irq_clr = 1;
    @(negedge clk) irq_clr = 0;
    chk(irq_flag === 0 && irq === 0, "R10 flag cleared", irq_flag, 0);

    send(8'hA4, 3'd0, 1'b0, 1'b1, "addr msb8");
    send(8'h3C, 3'd0, 1'b1, 1'b0, "lsb8 nack");
    send(8'hA0, 3'd3, 1'b0, 1'b1, "msb3");
    send(8'h16, 3'd5, 1'b1, 1'b1, "lsb5");
    send(8'h81, 3'd7, 1'b0, 1'b0, "msb7");
    send(8'h5A, 3'd1, 1'b1, 1'b1, "lsb1");
    lo_cyc = 0; hi_cyc = 0;
    send(8'hC3, 3'd0, 1'b0, 1'b1, "R7 zero lengths");
    lo_cyc = 2; hi_cyc = 3;
    send(8'h6D, 3'd0, 1'b1, 1'b1, "R7 uneven lengths");

    // double buffering: second byte written while first shifts
    @(negedge clk);
    frame_bits = 0; lsb_first = 0; slave_low = 1;
    irq_clr = 1; wr_en = 1; wr_data = 8'hE1; cap.delete();
    @(negedge clk) begin irq_clr = 0; wr_en = 0; end
    @(negedge clk);
    chk(tx_empty === 1, "R4 empty after load", tx_empty, 1);
    wr_en = 1; wr_data = 8'h2B;
    @(negedge clk) wr_en = 0;
    chk(tx_empty === 0, "R4 empty cleared while shifting", tx_empty, 0);
    wait_irq("R4 first of two");
    @(negedge clk) irq_clr = 1;
    @(negedge clk) irq_clr = 0;
    wait_irq("R4 second of two");
    chk(cap.size() == 18, "R4 two frames clocks", cap.size(), 18);
    for (int i = 0; i < 8 && cap.size() == 18; i++)
      chk(cap[9+i] == exp_bit(8'h2B, 1'b0, i), "R4 held byte bits", cap[9+i], exp_bit(8'h2B, 1'b0, i));

    // byte and stop together: byte goes first
    @(negedge clk);
    irq_clr = 1; wr_en = 1; wr_data = 8'h99; stop_req = 1; cap.delete();
    @(negedge clk) begin irq_clr = 0; wr_en = 0; stop_req = 0; end
    wait_free("R11 bus freed after stop");
    slave_low = 0;
    chk(cap.size() == 10, "R11 frame before stop", cap.size(), 10);
    for (int i = 0; i < 8 && cap.size() == 10; i++)
      chk(cap[i] == exp_bit(8'h99, 1'b0, i), "R11 frame bits", cap[i], exp_bit(8'h99, 1'b0, i));
    chk(stops == 1 && scl_o === 1 && sda_o === 1, "R11 stop seen", stops, 1);

    @(negedge clk) stop_req = 1;
    @(negedge clk) stop_req = 0;
    repeat (20) @(negedge clk);
    chk(bus_busy === 0 && stops == 1 && scl_o === 1 && sda_o === 1,
        "R11 stop ignored when idle", stops, 1);
    @(negedge clk) go_start = 1;
    @(negedge clk) go_start = 0;
    wait_irq("R2 second start");
    irq_en = 0;
    @(negedge clk);
    chk(irq === 0 && irq_flag === 1, "R10 masked irq", irq, 0);
    repeat (30) @(negedge clk);
    chk(bus_busy === 1 && stops == 1, "R11 idle stop not held", bus_busy, 1);
    @(negedge clk) stop_req = 1;
    @(negedge clk) stop_req = 0;
    wait_free("R11 second stop");
    chk(stops == 2, "R11 stop count", stops, 2);
    repeat (5) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule